// File: doc/BRIEF.md
# Accumulator Node Execution Core

This block is the execution core of one node in a mesh of identical programmable nodes. It runs a short program held in a private instruction store that is filled from outside through a load port; no instruction can write that store. The only working storage is a signed accumulator and one hidden backup register, which is reached solely by a save instruction (accumulator into backup) and a swap instruction (exchange the two).

Data moves between neighbouring nodes through a separate port unit. The core asks that unit for a blocking read or write on a named direction (or on the "any" and "last used" pseudo-directions). It then waits, frozen, until the unit reports completion. Arithmetic saturates at plus and minus 999. The program counter wraps to address 0 after the last valid instruction. A relative jump is clamped into the valid program range. An empty program keeps the core idle.

Top module: `acc_node_core`

## Requirements
- R1: Synchronous reset clears the accumulator, the backup register and the program counter and drops any port request. It keeps the instruction store and the program length, so the same program can run again after reset without reloading.
- R2: An instruction is 22 bits: opcode in [21:17], source direction in [16:14], destination direction in [13:11], signed immediate in [10:0]. Opcode 1 loads the immediate, 14 adds it and 16 subtracts it. Every value written into the accumulator is clamped to the range -999 to +999.
- R3: Opcode 7 replaces the accumulator with its two's-complement negation.
- R4: Opcode 5 copies the accumulator into the backup register. Opcode 6 exchanges the accumulator and the backup register.
- R5: Opcode 8 always jumps to the address in the low 4 bits of the immediate. Opcodes 9, 10, 11 and 12 jump there only when the accumulator is zero, nonzero, greater than zero or less than zero; otherwise the next instruction follows.
- R6: Opcode 13 adds the signed immediate to the program counter. A target above the last valid address is clamped to the last valid address, and a negative target is clamped to 0.
- R7: After the instruction at address (length - 1), execution continues at address 0. Entries at or above the length are never executed.
- R8: With a program length of 0, the core issues no port request and its program counter stays at 0 while run is high. Lengths above 16 are clamped to 16.
- R9: Opcode 2 reads from the source direction into the accumulator, 15 adds the read value and 17 subtracts it. A read is a request with the write flag low and the port field set to the source code. Direction codes: 0 up, 1 right, 2 down, 3 left, 4 last used, 5 any.
- R10: Opcode 3 issues a write of the accumulator to the destination direction. Opcode 4 first reads the source direction and then writes the read value to the destination direction, as two requests in that order.
- R11: While a port request is pending, the request stays asserted with unchanged fields and the program counter and accumulator do not change until the done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the execution state |
| run | input | 1 | Execute while high; sampled between instructions |
| ld_we | input | 1 | Write one instruction into the store |
| ld_addr | input | 4 | Store address for the write |
| ld_instr | input | 22 | Instruction word to store |
| ld_len_we | input | 1 | Write the program length |
| ld_len | input | 5 | Number of valid instructions (clamped to 16) |
| preq_valid | output | 1 | Port request pending |
| preq_write | output | 1 | 1 for a write, 0 for a read |
| preq_port | output | 3 | Direction code of the request |
| preq_data | output | 11 | Value to write |
| presp_done | input | 1 | One-cycle pulse: request completed |
| presp_data | input | 11 | Read value, valid with the done pulse |
| acc_o | output | 11 | Accumulator, signed |
| pc_o | output | 4 | Program counter |

## Verification
A wrong accumulator or backup value appears on the accumulator output at the end of the instruction that caused it, two cycles per non-port instruction. A swap can carry a corrupted backup value out later, where it becomes visible. A wrong program counter shows up as a skipped or repeated instruction, and so as a wrong accumulator a few cycles later. It also shows as a stuck or out-of-range value on the counter output, for example after a clamped relative jump or a wrap. A faulty port sequence shows up immediately on the request fields, in the order and contents of the reads and writes the port model records.

// File: rtl/anc_pkg.sv
package anc_pkg;

  localparam int OPW = 5;
  localparam int PSW = 3;

  typedef enum logic [OPW-1:0] {
    OP_NOP   = 5'd0,
    OP_MOVI  = 5'd1,
    OP_MOVPA = 5'd2,
    OP_MOVAP = 5'd3,
    OP_MOVPP = 5'd4,
    OP_SAV   = 5'd5,
    OP_SWP   = 5'd6,
    OP_NEG   = 5'd7,
    OP_JMP   = 5'd8,
    OP_JEZ   = 5'd9,
    OP_JNZ   = 5'd10,
    OP_JGZ   = 5'd11,
    OP_JLZ   = 5'd12,
    OP_JRO   = 5'd13,
    OP_ADDI  = 5'd14,
    OP_ADDP  = 5'd15,
    OP_SUBI  = 5'd16,
    OP_SUBP  = 5'd17
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_EXEC,
    ST_PORT
  } st_e;

  function automatic logic is_port_read(input op_e op);
    return (op == OP_MOVPA) || (op == OP_MOVPP) || (op == OP_ADDP) || (op == OP_SUBP);
  endfunction

endpackage

// File: rtl/anc_progmem.sv
module anc_progmem #(
  parameter int AW = 4,
  parameter int IW = 22
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [IW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [IW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [IW-1:0] mem [DEPTH];

  // Single write port, registered read: maps onto a block RAM.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/anc_alu.sv
module anc_alu
  import anc_pkg::*;
#(
  parameter int DW  = 11,
  parameter int SAT = 999
) (
  input  op_e                 op,
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  output logic signed [DW-1:0] y
);
  localparam int EW = DW + 2;
  localparam logic signed [EW-1:0] HI = EW'(SAT);
  localparam logic signed [EW-1:0] LO = -HI;

  logic signed [EW-1:0] ax, bx, r;

  always_comb begin
    ax = {{2{a[DW-1]}}, a};
    bx = {{2{b[DW-1]}}, b};
    case (op)
      OP_MOVI, OP_MOVPA: r = bx;
      OP_ADDI, OP_ADDP:  r = ax + bx;
      OP_SUBI, OP_SUBP:  r = ax - bx;
      OP_NEG:            r = -ax;
      default:           r = ax;
    endcase
    if (r > HI) begin
      y = HI[DW-1:0];
    end else if (r < LO) begin
      y = LO[DW-1:0];
    end else begin
      y = r[DW-1:0];
    end
  end
endmodule

// File: rtl/anc_branch.sv
module anc_branch
  import anc_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 11
) (
  input  op_e                  op,
  input  logic [AW-1:0]        pc,
  input  logic signed [DW-1:0] acc,
  input  logic signed [DW-1:0] imm,
  input  logic [AW:0]          len,
  output logic [AW-1:0]        seq_pc,
  output logic [AW-1:0]        next_pc
);
  localparam int EW = DW + 2;

  logic [AW:0]          pc_inc;
  logic signed [EW-1:0] pcx, immx, lastx, tgt;
  logic [AW-1:0]        rel_pc;
  logic                 taken;

  always_comb begin
    pc_inc = {1'b0, pc} + 1'b1;
    seq_pc = (pc_inc >= len) ? '0 : pc_inc[AW-1:0];

    pcx   = $signed({{(EW-AW){1'b0}}, pc});
    immx  = {{2{imm[DW-1]}}, imm};
    lastx = $signed({{(EW-AW-1){1'b0}}, len}) - 1;
    tgt   = pcx + immx;
    if (tgt < 0) begin
      rel_pc = '0;
    end else if (tgt > lastx) begin
      rel_pc = lastx[AW-1:0];
    end else begin
      rel_pc = tgt[AW-1:0];
    end

    case (op)
      OP_JMP:  taken = 1'b1;
      OP_JEZ:  taken = (acc == 0);
      OP_JNZ:  taken = (acc != 0);
      OP_JGZ:  taken = (acc > 0);
      OP_JLZ:  taken = (acc < 0);
      default: taken = 1'b0;
    endcase

    if (op == OP_JRO) begin
      next_pc = rel_pc;
    end else if (taken) begin
      next_pc = imm[AW-1:0];
    end else begin
      next_pc = seq_pc;
    end
  end
endmodule

// File: rtl/acc_node_core.sv
module acc_node_core
  import anc_pkg::*;
#(
  parameter int AW  = 4,
  parameter int DW  = 11,
  parameter int SAT = 999
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         run,
  input  logic                         ld_we,
  input  logic [AW-1:0]                ld_addr,
  input  logic [OPW+2*PSW+DW-1:0]      ld_instr,
  input  logic                         ld_len_we,
  input  logic [AW:0]                  ld_len,
  output logic                         preq_valid,
  output logic                         preq_write,
  output logic [PSW-1:0]               preq_port,
  output logic signed [DW-1:0]         preq_data,
  input  logic                         presp_done,
  input  logic signed [DW-1:0]         presp_data,
  output logic signed [DW-1:0]         acc_o,
  output logic [AW-1:0]                pc_o
);
  localparam int DEPTH = 1 << AW;
  localparam int IW    = OPW + 2 * PSW + DW;
  localparam logic [AW:0] LEN_MAX = (AW + 1)'(DEPTH);

  st_e                  st_q;
  logic [AW-1:0]        pc_q;
  logic signed [DW-1:0] acc_q, bak_q;
  logic [AW:0]          len_q;
  op_e                  cur_op;
  logic [PSW-1:0]       cur_dst;

  logic [IW-1:0]        mem_q;
  op_e                  dec_op;
  logic [PSW-1:0]       dec_src, dec_dst;
  logic signed [DW-1:0] dec_imm;

  op_e                  alu_op;
  logic signed [DW-1:0] alu_b, alu_y;
  logic [AW-1:0]        br_seq, br_next;

  // Program length survives reset, like the store itself.
  always_ff @(posedge clk) begin
    if (ld_len_we) begin
      len_q <= (ld_len > LEN_MAX) ? LEN_MAX : ld_len;
    end
  end

  anc_progmem #(.AW(AW), .IW(IW)) u_mem (
    .clk   (clk),
    .we    (ld_we),
    .waddr (ld_addr),
    .wdata (ld_instr),
    .raddr (pc_q),
    .rdata (mem_q)
  );

  always_comb begin
    dec_op  = op_e'(mem_q[IW-1 -: OPW]);
    dec_src = mem_q[DW+2*PSW-1 -: PSW];
    dec_dst = mem_q[DW+PSW-1 -: PSW];
    dec_imm = mem_q[DW-1:0];
    alu_op  = (st_q == ST_PORT) ? cur_op : dec_op;
    alu_b   = (st_q == ST_PORT) ? presp_data : dec_imm;
  end

  anc_alu #(.DW(DW), .SAT(SAT)) u_alu (
    .op (alu_op),
    .a  (acc_q),
    .b  (alu_b),
    .y  (alu_y)
  );

  anc_branch #(.AW(AW), .DW(DW)) u_br (
    .op      (dec_op),
    .pc      (pc_q),
    .acc     (acc_q),
    .imm     (dec_imm),
    .len     (len_q),
    .seq_pc  (br_seq),
    .next_pc (br_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      pc_q       <= '0;
      acc_q      <= '0;
      bak_q      <= '0;
      preq_valid <= 1'b0;
      preq_write <= 1'b0;
      preq_port  <= '0;
      preq_data  <= '0;
      cur_op     <= OP_NOP;
      cur_dst    <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (run && (len_q != '0)) begin
            st_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (!run || (len_q == '0)) begin
            st_q <= ST_IDLE;
          end else if ({1'b0, pc_q} >= len_q) begin
            pc_q <= '0;
          end else begin
            st_q <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          cur_op  <= dec_op;
          cur_dst <= dec_dst;
          if (is_port_read(dec_op)) begin
            preq_valid <= 1'b1;
            preq_write <= 1'b0;
            preq_port  <= dec_src;
            st_q       <= ST_PORT;
          end else if (dec_op == OP_MOVAP) begin
            preq_valid <= 1'b1;
            preq_write <= 1'b1;
            preq_port  <= dec_dst;
            preq_data  <= acc_q;
            st_q       <= ST_PORT;
          end else begin
            case (dec_op)
              OP_MOVI, OP_ADDI, OP_SUBI, OP_NEG: acc_q <= alu_y;
              OP_SAV: bak_q <= acc_q;
              OP_SWP: begin
                acc_q <= bak_q;
                bak_q <= acc_q;
              end
              default: ;
            endcase
            pc_q <= br_next;
            st_q <= ST_FETCH;
          end
        end
        ST_PORT: begin
          if (presp_done) begin
            if (!preq_write && (cur_op == OP_MOVPP)) begin
              preq_write <= 1'b1;
              preq_port  <= cur_dst;
              preq_data  <= presp_data;
            end else begin
              if (!preq_write) begin
                acc_q <= alu_y;
              end
              preq_valid <= 1'b0;
              pc_q       <= br_seq;
              st_q       <= ST_FETCH;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign acc_o = acc_q;
  assign pc_o  = pc_q;
endmodule

// File: rtl/anc_checker.sv
module anc_checker #(
  parameter int AW  = 4,
  parameter int DW  = 11,
  parameter int SAT = 999
) (
  input logic                 clk,
  input logic                 rst,
  input logic signed [DW-1:0] acc,
  input logic [AW-1:0]        pc,
  input logic [AW:0]          prog_len,
  input logic                 preq_valid,
  input logic                 preq_write,
  input logic [2:0]           preq_port,
  input logic                 presp_done
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (acc == 0 && pc == '0 && !preq_valid));

  assert_acc_saturated_R2: assert property (@(posedge clk) disable iff (rst)
    (acc <= SAT) && (acc >= -SAT));

  assert_pc_in_range_R7: assert property (@(posedge clk) disable iff (rst)
    preq_valid |-> ({1'b0, pc} < prog_len));

  assert_empty_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (prog_len == '0 && !preq_valid) |=> !preq_valid);

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (preq_valid && !presp_done) |=> (preq_valid && $stable(preq_write) &&
      $stable(preq_port) && $stable(pc) && $stable(acc)));
endmodule

bind acc_node_core anc_checker #(.AW(AW), .DW(DW), .SAT(SAT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .acc        (acc_q),
  .pc         (pc_q),
  .prog_len   (len_q),
  .preq_valid (preq_valid),
  .preq_write (preq_write),
  .preq_port  (preq_port),
  .presp_done (presp_done)
);

// File: tb/acc_node_core_bench.sv
module acc_node_core_bench;
  localparam int CLK_PERIOD = 10;

  // Opcodes and direction codes as stated in the requirements
  localparam int NOP = 0, MOVI = 1, MOVPA = 2, MOVAP = 3, MOVPP = 4, SAV = 5, SWP = 6;
  localparam int NEG = 7, JMP = 8, JEZ = 9, JNZ = 10, JGZ = 11, JLZ = 12, JRO = 13;
  localparam int ADDI = 14, ADDP = 15, SUBI = 16, SUBP = 17;
  localparam int UP = 0, RIGHT = 1, DOWN = 2, LEFT = 3, LAST = 4, ANY = 5;

  // Vector table: MOVI va ; op1 ; op2 ; op3 ; JMP 4 -> expected accumulator
  localparam int NV = 18;
  localparam int VA [NV] = '{5, 990, -990, 10, -7, 123, 40, 0, 5, 5, -5, 5, -5, 0, 9, 9, 0, 0};
  localparam int O1 [NV] = '{ADDI, ADDI, SUBI, SUBI, NEG, SAV, SWP, JEZ, JEZ, JNZ, JGZ, JGZ, JLZ, JLZ, JMP, JRO, MOVI, MOVI};
  localparam int I1 [NV] = '{7, 50, 50, 25, 0, 0, 0, 3, 3, 3, 3, 3, 3, 3, 3, 2, 1023, -1024};
  localparam int O2 [NV] = '{NOP, NOP, NOP, NOP, NOP, MOVI, NOP, ADDI, ADDI, ADDI, ADDI, ADDI, ADDI, ADDI, ADDI, ADDI, NOP, NOP};
  localparam int I2 [NV] = '{0, 0, 0, 0, 0, 4, 0, 100, 100, 100, 100, 100, 100, 100, 100, 100, 0, 0};
  localparam int O3 [NV] = '{NOP, NOP, NOP, NOP, NOP, SWP, NOP, ADDI, ADDI, ADDI, ADDI, ADDI, ADDI, ADDI, ADDI, ADDI, NOP, NOP};
  localparam int I3 [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1, 1, 1, 1, 0, 0};
  localparam int EX [NV] = '{12, 999, -999, -15, 7, 123, 0, 1, 106, 6, 96, 6, -4, 101, 10, 10, 999, -999};
  // Requirement of each vector: R2 arithmetic/saturation, R3 negate, R4 save/swap,
  // R5 jumps, R6 relative jump
  localparam int VR [NV] = '{2, 2, 2, 2, 3, 4, 4, 5, 5, 5, 5, 5, 5, 5, 5, 6, 2, 2};

  localparam int RDQ [5] = '{77, 300, 800, 42, 10};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic ld_we = 1'b0;
  logic [3:0] ld_addr = '0;
  logic [21:0] ld_instr = '0;
  logic ld_len_we = 1'b0;
  logic [4:0] ld_len = '0;
  logic preq_valid, preq_write;
  logic [2:0] preq_port;
  logic signed [10:0] preq_data;
  logic presp_done = 1'b0;
  logic signed [10:0] presp_data = '0;
  logic signed [10:0] acc_o;
  logic [3:0] pc_o;

  int checks = 0;
  int errors = 0;
  int lat = 2;
  int lg_n = 0;
  int lg_wr [16];
  int lg_port [16];
  int lg_data [16];

  acc_node_core u_acc_node_core (
    .clk(clk), .rst(rst), .run(run),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_instr(ld_instr),
    .ld_len_we(ld_len_we), .ld_len(ld_len),
    .preq_valid(preq_valid), .preq_write(preq_write), .preq_port(preq_port),
    .preq_data(preq_data), .presp_done(presp_done), .presp_data(presp_data),
    .acc_o(acc_o), .pc_o(pc_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Port unit model: completes each request after lat falling edges
  initial begin
    int cnt = 0;
    int ri = 0;
    forever begin
      @(negedge clk);
      if (presp_done) begin
        presp_done = 1'b0;
        cnt = 0;
      end else if (preq_valid) begin
        cnt++;
        if (cnt >= lat) begin
          if (lg_n < 16) begin
            lg_wr[lg_n] = int'(preq_write);
            lg_port[lg_n] = int'(preq_port);
            lg_data[lg_n] = int'(preq_data);
          end
          lg_n++;
          if (!preq_write) begin
            presp_data = 11'(RDQ[ri % 5]);
            ri++;
          end
          presp_done = 1'b1;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [21:0] mk(input int op, input int s, input int d, input int imm);
    return {op[4:0], s[2:0], d[2:0], imm[10:0]};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(input int a, input logic [21:0] w);
    @(negedge clk);
    ld_we = 1'b1;
    ld_addr = 4'(a);
    ld_instr = w;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic set_len(input int n);
    @(negedge clk);
    ld_len_we = 1'b1;
    ld_len = 5'(n);
    @(negedge clk);
    ld_len_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_for(input int n);
    @(negedge clk);
    run = 1'b1;
    repeat (n) @(negedge clk);
    run = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    int base;
    int seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    set_len(0);
    do_reset();
    chk("R1 reset acc", int'(acc_o), 0);
    chk("R1 reset pc", int'(pc_o), 0);
    chk("R1 reset request", int'(preq_valid), 0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      do_reset();
      load(0, mk(MOVI, 0, 0, VA[v]));
      load(1, mk(O1[v], 0, 0, I1[v]));
      load(2, mk(O2[v], 0, 0, I2[v]));
      load(3, mk(O3[v], 0, 0, I3[v]));
      load(4, mk(JMP, 0, 0, 4));
      set_len(5);
      run_for(40);
      checks++;
      if (int'(acc_o) != EX[v]) begin
        errors++;
        $display("FAIL R%0d vector %0d actual %0d expected %0d", VR[v], v, int'(acc_o), EX[v]);
      end
    end

    // R1: reset keeps the program; rerun gives the same result
    do_reset();
    chk("R1 acc after reset", int'(acc_o), 0);
    chk("R1 pc after reset", int'(pc_o), 0);
    run_for(40);
    chk("R1 rerun without reload", int'(acc_o), EX[NV-1]);

    // R7: wrap at length 2; address 2 holds ADDI 500 and must never run
    do_reset();
    load(0, mk(ADDI, 0, 0, 1));
    load(1, mk(ADDI, 0, 0, 2));
    load(2, mk(ADDI, 0, 0, 500));
    set_len(2);
    run_for(40);
    chk("R7 wrap acc below 100", int'(acc_o < 100), 1);
    chk("R7 wrap acc at least 9", int'(acc_o >= 9), 1);
    chk("R7 wrap acc pattern", int'((acc_o % 3) <= 1), 1);
    chk("R7 pc below length", int'(pc_o < 2), 1);

    // R6: relative jump past the end clamps to the last address
    do_reset();
    load(0, mk(MOVI, 0, 0, 7));
    load(1, mk(JRO, 0, 0, 10));
    load(2, mk(ADDI, 0, 0, 100));
    load(3, mk(JMP, 0, 0, 3));
    set_len(4);
    run_for(30);
    chk("R6 clamped pc", int'(pc_o), 3);
    chk("R6 clamped acc", int'(acc_o), 7);

    // R8: empty program stays idle
    do_reset();
    set_len(0);
    base = lg_n;
    seen = 0;
    @(negedge clk);
    run = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (preq_valid) seen = 1;
    end
    chk("R8 empty pc", int'(pc_o), 0);
    chk("R8 empty no request", seen + (lg_n - base), 0);
    run = 1'b0;
    // R8: oversized length clamps to 16 (address 15 reachable, wraps)
    do_reset();
    for (int a = 0; a < 15; a++) load(a, mk(NOP, 0, 0, 0));
    load(15, mk(JMP, 0, 0, 15));
    set_len(31);
    run_for(60);
    chk("R8 length clamp reaches 15", int'(pc_o), 15);

    // R11: stall on a slow read (value 77)
    do_reset();
    load(0, mk(MOVPA, UP, 0, 0));
    load(1, mk(JMP, 0, 0, 1));
    set_len(2);
    lat = 30;
    @(negedge clk);
    run = 1'b1;
    repeat (15) @(negedge clk);
    chk("R11 request held", int'(preq_valid), 1);
    chk("R11 pc frozen", int'(pc_o), 0);
    chk("R11 acc frozen", int'(acc_o), 0);
    repeat (40) @(negedge clk);
    run = 1'b0;
    repeat (8) @(negedge clk);
    chk("R11 read lands after done", int'(acc_o), 77);

    // R9/R10: full port sequence, reads 300, 800, 42, 10
    do_reset();
    lat = 2;
    load(0, mk(MOVPA, UP, 0, 0));
    load(1, mk(ADDP, LEFT, 0, 0));
    load(2, mk(MOVAP, 0, RIGHT, 0));
    load(3, mk(MOVPP, ANY, DOWN, 0));
    load(4, mk(SUBP, LAST, 0, 0));
    load(5, mk(JMP, 0, 0, 5));
    set_len(6);
    base = lg_n;
    run_for(80);
    chk("R9 request count", lg_n - base, 6);
    chk("R9 read up kind", lg_wr[base], 0);
    chk("R9 read up port", lg_port[base], UP);
    chk("R9 read left port", lg_port[base+1], LEFT);
    chk("R10 write right kind", lg_wr[base+2], 1);
    chk("R10 write right port", lg_port[base+2], RIGHT);
    chk("R10 write saturated acc", lg_data[base+2], 999);
    chk("R10 move read any", lg_port[base+3] + 10 * lg_wr[base+3], ANY);
    chk("R10 move write down", lg_port[base+4] + 10 * lg_wr[base+4], DOWN + 10);
    chk("R10 move write data", lg_data[base+4], 42);
    chk("R9 read last port", lg_port[base+5], LAST);
    chk("R9 final acc", int'(acc_o), 989);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule